// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block forms a 32-bit linear address from up to three terms: a displacement, a base register value and an index register value scaled by 1, 2, 4 or 8. The displacement is always added. The base and the index each come with their own valid bit, and a term whose valid bit is low contributes zero. With these rules one datapath covers every operand form: displacement only, base only, displacement plus base, displacement plus scaled index, and all three terms together. Memory is one flat 32-bit space with no segment offset, so the sum wraps modulo 2^32.

For a load or store of 1, 2 or 4 bytes, the unit also returns a little-endian byte-lane enable for each byte of the aligned 4-byte word that holds the address. It raises a misaligned flag when the access runs past the end of that word. Each request is sampled on a clock edge when `valid_i` is high. Its results are registered and are held until the next request.

Top module: `lin_addr_gen`

## Requirements
- R1: `addr_o` equals disp_i + base term + scaled index term, taken modulo 2^32.
- R2: `scale_i` is a shift amount: 00 gives ×1, 01 gives ×2, 10 gives ×4 and 11 gives ×8 on the index.
- R3: When `base_vld_i` is low the base term is zero, and when `idx_vld_i` is low the index term is zero, whatever values `base_i` or `idx_i` carry.
- R4: A request sampled on a rising edge with `valid_i` high shows its results on the outputs after that edge. `valid_o` is high for exactly the cycles that follow a sampled request.
- R5: While `valid_i` is low, `addr_o`, `lane_en_o` and `misalign_o` keep their last values.
- R6: `size_i` gives the access width: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes and 11 is no access. Bit k of `lane_en_o` is byte lane k, with lane 0 the lowest address of the aligned word. Lane k is set when addr[1:0] ≤ k < addr[1:0] + width.
- R7: `misalign_o` is 1 when addr[1:0] + width > 4. A 1-byte access is never misaligned.
- R8: With `size_i` = 11, `lane_en_o` is 0000 and `misalign_o` is 0.
- R9: After reset, `valid_o`, `addr_o`, `lane_en_o` and `misalign_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| disp_i | input | 32 | Displacement term |
| base_i | input | 32 | Base register value |
| base_vld_i | input | 1 | Base term present |
| idx_i | input | 32 | Index register value |
| idx_vld_i | input | 1 | Index term present |
| scale_i | input | 2 | Index shift amount |
| size_i | input | 2 | Access width code |
| valid_o | output | 1 | Results belong to a new request |
| addr_o | output | 32 | Linear address |
| lane_en_o | output | 4 | Byte-lane enables, lane 0 lowest |
| misalign_o | output | 1 | Access crosses a 4-byte boundary |

## Verification
Every result of this block is due one cycle after the request is sampled: the address, lane enables, misalign flag and `valid_o` all come from the same output register. The bench therefore drives each request on a falling edge and lets the next rising edge capture it. It checks all four outputs on the falling edge that follows, then drops `valid_i` and checks on the next falling edge that `valid_o` has fallen and that the other outputs have held. Requests sent back to back are checked one per falling edge. This confirms that a new request replaces the previous results without any added delay.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_NONE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/agu_scale.sv
module agu_scale #(
  parameter int W       = 32,
  parameter int SCALE_W = 2
) (
  input  logic [W-1:0]       idx_i,
  input  logic               vld_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [W-1:0]       term_o
);
  always_comb term_o = vld_i ? (idx_i << scale_i) : '0;
endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int W = 32
) (
  input  logic [W-1:0] disp_i,
  input  logic [W-1:0] base_i,
  input  logic         base_vld_i,
  input  logic [W-1:0] idx_term_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] base_term;
  always_comb begin
    base_term = base_vld_i ? base_i : '0;
    sum_o     = disp_i + base_term + idx_term_i;  // wraps modulo 2^W
  end
endmodule

// File: rtl/agu_lanes.sv
module agu_lanes
  import agu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output logic [LANES-1:0] lane_en_o,
  output logic             misalign_o
);
  logic [CNT_W-1:0] nbytes;
  logic [CNT_W-1:0] off_ext;
  logic [CNT_W-1:0] end_ext;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes = CNT_W'(1);
      SZ_HALF: nbytes = CNT_W'(2);
      SZ_WORD: nbytes = CNT_W'(LANES);
      default: nbytes = '0;
    endcase
    off_ext    = CNT_W'(off_i);
    end_ext    = off_ext + nbytes;
    misalign_o = (nbytes != '0) && (end_ext > CNT_W'(LANES));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_en_o[k] = (CNT_W'(k) >= off_ext) && (CNT_W'(k) < end_ext);
  end
endmodule

// File: rtl/lin_addr_gen.sv
module lin_addr_gen
  import agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2,
  parameter int LANES   = 4,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  disp_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic               base_vld_i,
  input  logic [ADDR_W-1:0]  idx_i,
  input  logic               idx_vld_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [1:0]         size_i,
  output logic               valid_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [LANES-1:0]   lane_en_o,
  output logic               misalign_o
);
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  lane_d;
  logic              mis_d;

  agu_scale #(.W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
    .idx_i  (idx_i),
    .vld_i  (idx_vld_i),
    .scale_i(scale_i),
    .term_o (idx_term)
  );

  agu_sum #(.W(ADDR_W)) u_sum (
    .disp_i    (disp_i),
    .base_i    (base_i),
    .base_vld_i(base_vld_i),
    .idx_term_i(idx_term),
    .sum_o     (addr_d)
  );

  agu_lanes #(.LANES(LANES)) u_lanes (
    .off_i     (addr_d[OFF_W-1:0]),
    .size_i    (acc_size_e'(size_i)),
    .lane_en_o (lane_d),
    .misalign_o(mis_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      addr_o     <= '0;
      lane_en_o  <= '0;
      misalign_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o     <= addr_d;
        lane_en_o  <= lane_d;
        misalign_o <= mis_d;
      end
    end
  end

  p_valid_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(addr_o) && $stable(lane_en_o) && $stable(misalign_o)));
  p_byte_one_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b00) |=> ($countones(lane_en_o) == 1 && !misalign_o));
  p_misalign_top_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && misalign_o) |-> lane_en_o[LANES-1]);
  p_none_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b11) |=> (lane_en_o == '0 && !misalign_o));
  p_word_lanes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !misalign_o && lane_en_o[0] && lane_en_o[LANES-1]) |->
      (addr_o[OFF_W-1:0] == '0));
endmodule

// File: tb/lin_addr_gen_tb_top.sv
`timescale 1ns/1ps
module lin_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] disp_i = '0, base_i = '0, idx_i = '0;
  logic        base_vld_i = 1'b0, idx_vld_i = 1'b0;
  logic [1:0]  scale_i = '0, size_i = '0;
  logic        valid_o;
  logic [31:0] addr_o;
  logic [3:0]  lane_en_o;
  logic        misalign_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .disp_i(disp_i), .base_i(base_i), .base_vld_i(base_vld_i),
    .idx_i(idx_i), .idx_vld_i(idx_vld_i), .scale_i(scale_i), .size_i(size_i),
    .valid_o(valid_o), .addr_o(addr_o), .lane_en_o(lane_en_o), .misalign_o(misalign_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] d, logic [31:0] b, bit bv,
                                           logic [31:0] x, bit xv, logic [1:0] s);
    logic [31:0] mult;
    mult = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : (s == 2'd2) ? 32'd4 : 32'd8;
    return d + (bv ? b : 32'd0) + (xv ? x * mult : 32'd0);
  endfunction

  function automatic int width_of(logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
  endfunction

  function automatic logic [3:0] exp_lanes(logic [31:0] a, logic [1:0] sz);
    logic [3:0] r;
    int off;
    int n;
    r = '0;
    off = int'(a[1:0]);
    n = width_of(sz);
    for (int k = 0; k < 4; k++) if (k >= off && k < off + n) r[k] = 1'b1;
    return r;
  endfunction

  function automatic bit exp_mis(logic [31:0] a, logic [1:0] sz);
    return (width_of(sz) != 0) && (int'(a[1:0]) + width_of(sz) > 4);
  endfunction

  // drive on falling edge, capture on rising, check on next falling; valid_i left high
  task automatic issue(input string req, input logic [31:0] d, input logic [31:0] b, input bit bv,
                       input logic [31:0] x, input bit xv, input logic [1:0] s, input logic [1:0] sz);
    logic [31:0] ea;
    valid_i = 1'b1; disp_i = d; base_i = b; base_vld_i = bv;
    idx_i = x; idx_vld_i = xv; scale_i = s; size_i = sz;
    ea = exp_addr(d, b, bv, x, xv, s);
    @(posedge clk); @(negedge clk);
    chk(valid_o == 1'b1, {req, " R4 valid_o"}, 32'(valid_o), 32'd1);
    chk(addr_o == ea, {req, " addr"}, addr_o, ea);
    chk(lane_en_o == exp_lanes(ea, sz), {req, " R6 lanes"}, 32'(lane_en_o), 32'(exp_lanes(ea, sz)));
    chk(misalign_o == exp_mis(ea, sz), {req, " R7 misalign"}, 32'(misalign_o), 32'(exp_mis(ea, sz)));
  endtask

  task automatic idle_check(input string req);
    logic [31:0] a;
    logic [3:0]  l;
    logic        m;
    a = addr_o; l = lane_en_o; m = misalign_o;
    valid_i = 1'b0;
    disp_i = 32'hDEAD_BEEF; base_i = 32'h1234_5677; base_vld_i = 1'b1;
    idx_i = 32'h0BAD_F00D; idx_vld_i = 1'b1; scale_i = 2'd3; size_i = 2'b10;
    @(posedge clk); @(negedge clk);
    chk(valid_o == 1'b0, {req, " R4 valid drop"}, 32'(valid_o), 32'd0);
    chk(addr_o == a && lane_en_o == l && misalign_o == m, {req, " R5 hold"}, addr_o, a);
  endtask

  task automatic t_reset;
    chk(valid_o == 1'b0, "R9 valid_o", 32'(valid_o), 32'd0);
    chk(addr_o == 32'd0, "R9 addr_o", addr_o, 32'd0);
    chk(lane_en_o == 4'd0 && misalign_o == 1'b0, "R9 lanes/misalign",
        {27'd0, misalign_o, lane_en_o}, 32'd0);
  endtask

  task automatic t_forms;
    issue("R1 disp only", 32'h0000_1F40, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, 1'b0, 2'd0, 2'b10);
    idle_check("R5 after disp");
    issue("R1 base only", 32'd0, 32'h8000_0100, 1'b1, 32'd7, 1'b0, 2'd2, 2'b10);
    issue("R1 disp+base", 32'd20, 32'h0000_3000, 1'b1, 32'd0, 1'b0, 2'd0, 2'b01);
    issue("R1 disp+index", 32'h100, 32'd0, 1'b0, 32'd9, 1'b1, 2'd1, 2'b00);
    issue("R1 all three", 32'h40, 32'h1000, 1'b1, 32'h30, 1'b1, 2'd3, 2'b10);
    idle_check("R5 after all three");
  endtask

  task automatic t_scales;
    for (int s = 0; s < 4; s++)
      issue("R2 scale", 32'd3, 32'd0, 1'b0, 32'h0000_0105, 1'b1, 2'(s), 2'b00);
    idle_check("R5 after scales");
  endtask

  task automatic t_absent;
    issue("R3 base ignored", 32'h10, 32'hAAAA_5555, 1'b0, 32'h4, 1'b1, 2'd2, 2'b10);
    chk(addr_o == 32'h20, "R3 base value unused", addr_o, 32'h20);
    issue("R3 index ignored", 32'h10, 32'h100, 1'b1, 32'h5555_AAAA, 1'b0, 2'd3, 2'b10);
    chk(addr_o == 32'h110, "R3 index value unused", addr_o, 32'h110);
    idle_check("R5 after absent");
  endtask

  task automatic t_wrap;
    issue("R1 wrap", 32'hFFFF_FFF0, 32'h0000_0020, 1'b1, 32'h2000_0001, 1'b1, 2'd3, 2'b10);
    chk(addr_o == 32'h0000_0018, "R1 wrap value", addr_o, 32'h0000_0018);
    idle_check("R5 after wrap");
  endtask

  task automatic t_lanes;
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++)
        issue("R6 R7 R8 lane sweep", 32'h0000_2000 + 32'(off), 32'd0, 1'b0, 32'd0, 1'b0, 2'd0, 2'(sz));
    issue("R8 none", 32'h0000_0003, 32'd0, 1'b0, 32'd0, 1'b0, 2'd0, 2'b11);
    chk(lane_en_o == 4'd0 && misalign_o == 1'b0, "R8 no lanes", 32'(lane_en_o), 32'd0);
    issue("R7 half at 3", 32'h0000_0003, 32'd0, 1'b0, 32'd0, 1'b0, 2'd0, 2'b01);
    chk(lane_en_o == 4'b1000 && misalign_o == 1'b1, "R7 half crossing",
        {27'd0, misalign_o, lane_en_o}, 32'h18);
    idle_check("R5 after lanes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forms();
    t_scales();
    t_absent();
    t_wrap();
    t_lanes();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule